// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Generator

This block produces the active-low, per-byte-lane write enables for an asynchronous second-level cache data RAM during burst writes. A one-cycle start pulse opens a transfer and captures the byte-lane mask, the line-fill flag, the memory type and the one-bit write-timing setting. Each data beat then drives the strobes low on the enabled lanes until the transfer acknowledge for that beat arrives. The strobes go high again at one of two points:

- the falling clock edge inside the acknowledge cycle, or
- the next rising edge, together with the acknowledge itself.

The choice between them depends on the timing bit, the memory type and whether the transfer is a line fill from main memory.

After each acknowledged beat there is one idle cycle, so that every beat forms its own pulse. The transfer ends after a fixed number of beats. When the memory type is pipelined burst SRAM, the same configuration bit is decoded instead as the address-strobe mode select, which is reported on its own output.

Top module: `sram_wpulse_gen`

## Requirements
- R1: In a write beat, every lane whose `lane_en` bit was 1 at start drives `we_n` low from the rising edge that opens the beat, and stays low through any cycles that have no acknowledge.
- R2: With the early release in effect, `we_n` of the enabled lanes returns high at the falling clock edge of the cycle in which `xfer_ack` is 1.
- R3: When `mem_kind` is 0 (asynchronous), the timing bit is 1 and `line_fill` is 1, `we_n` stays low for the whole acknowledge cycle and returns high on the rising edge that ends it.
- R4: When the memory is asynchronous and the timing bit is 1 but `line_fill` is 0, the early release of R2 applies.
- R5: When `mem_kind` is 1 (synchronous burst) or 3 (reserved), the timing bit is treated as 0, so the early release applies.
- R6: `adsp_sel` equals the live timing bit only when `mem_kind` is 2 (pipelined burst). It is 0 for every other type. Write strobes in pipelined mode use the early release.
- R7: A lane whose `lane_en` bit was 0 at start keeps `we_n` high for the whole transfer.
- R8: After each acknowledged beat, all `we_n` bits are high for exactly one cycle. An acknowledge in that cycle is ignored. The next beat then begins.
- R9: After `BEATS` acknowledged beats the transfer ends. In idle, all `we_n` bits are high and `xfer_ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| wr_start | input | 1 | One-cycle pulse that opens a write transfer (ignored while busy) |
| line_fill | input | 1 | Transfer is a cache line fill from main memory (captured at start) |
| lane_en | input | LANES | Byte lanes to write (captured at start) |
| wtime_cfg | input | 1 | Write-timing / address-strobe configuration bit |
| mem_kind | input | 2 | 0 async, 1 sync burst, 2 pipelined burst, 3 reserved |
| xfer_ack | input | 1 | Transfer acknowledge for the current beat, active high |
| we_n | output | LANES | Per-lane write enable, active low |
| adsp_sel | output | 1 | Pipelined mode: address-strobe mode select decoded from the config bit |

## Verification
The bench samples each strobe in both halves of every acknowledge cycle, and again in the following gap cycle. A design that picked the wrong release point would show its fault in one of those samples. In the early case it would hold the strobe through the second half of the cycle, and in the late case it would drop the strobe early.

The bench also runs the timing bit at 1 in every combination that must not produce the late release: no line fill, synchronous type, reserved type and pipelined type. A decode that ignored the flag or the type would therefore stretch those pulses.

Other runs cover wait states, a partial lane mask, an acknowledge in the gap cycle and an acknowledge while idle. These catch a design that releases the strobe too early, writes the masked-off lanes, merges pulses or counts too many beats.

// File: rtl/sramw_pkg.sv
package sramw_pkg;

    typedef enum logic [1:0] {
        MEM_ASYNC = 2'd0,
        MEM_SYNC  = 2'd1,
        MEM_PIPE  = 2'd2,
        MEM_RSVD  = 2'd3
    } mem_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_GAP   = 2'd2
    } wphase_e;

    typedef struct packed {
        logic late_release;
        logic adsp_sel;
    } wcfg_t;

    // Late release only for asynchronous RAM, timing bit set, line fill.
    function automatic logic want_late(logic [1:0] kind, logic tbit, logic fill);
        return (kind == MEM_ASYNC) && tbit && fill;
    endfunction

    // Address-strobe mode is the same bit, meaningful only for pipelined RAM.
    function automatic logic want_adsp(logic [1:0] kind, logic tbit);
        return (kind == MEM_PIPE) && tbit;
    endfunction

endpackage

// File: rtl/sramw_cfg_latch.sv
module sramw_cfg_latch
    import sramw_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             line_fill,
    input  logic [LANES-1:0] lane_en,
    input  logic             wtime_cfg,
    input  logic [1:0]       mem_kind,
    output wcfg_t            cfg,
    output logic [LANES-1:0] mask_q
);

    logic late_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            late_q <= 1'b0;
            mask_q <= '0;
        end else if (capture) begin
            late_q <= want_late(mem_kind, wtime_cfg, line_fill);
            mask_q <= lane_en;
        end
    end

    always_comb begin
        cfg.late_release = late_q;
        cfg.adsp_sel     = want_adsp(mem_kind, wtime_cfg);
    end

    // R6
    adsp_only_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_kind != MEM_PIPE) |-> !cfg.adsp_sel);

    // R5
    late_needs_async_chk: assert property (@(posedge clk) disable iff (rst)
        (capture && mem_kind != MEM_ASYNC) |=> !late_q);

endmodule

// File: rtl/sramw_beat_fsm.sv
module sramw_beat_fsm
    import sramw_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    ack,
    output wphase_e phase,
    output logic    capture
);

    localparam int CW = $clog2(BEATS + 1);

    wphase_e        phase_q, phase_d;
    logic [CW-1:0]  done_q, done_d;

    assign capture = (phase_q == PH_IDLE) && start;
    assign phase   = phase_q;

    always_comb begin
        phase_d = phase_q;
        done_d  = done_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_PULSE;
                    done_d  = '0;
                end
            end
            PH_PULSE: begin
                if (ack) begin
                    done_d = done_q + 1'b1;
                    if (done_q == CW'(BEATS - 1)) phase_d = PH_IDLE;
                    else                          phase_d = PH_GAP;
                end
            end
            PH_GAP:  phase_d = PH_PULSE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= '0;
        end else begin
            phase_q <= phase_d;
            done_q  <= done_d;
        end
    end

    // R8
    gap_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PULSE && ack) |=> (phase_q != PH_PULSE));

    // R8
    gap_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GAP) |=> (phase_q == PH_PULSE));

    // R9
    beat_limit_chk: assert property (@(posedge clk) disable iff (rst)
        done_q <= CW'(BEATS));

endmodule

// File: rtl/sramw_strobe_drv.sv
module sramw_strobe_drv
    import sramw_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  wphase_e          phase,
    input  logic             ack,
    input  logic             late_release,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] we_n
);

    logic in_pulse;
    logic cut_q;

    assign in_pulse = (phase == PH_PULSE);

    // Falling-edge capture of the acknowledge: cuts the strobe in the second half.
    always_ff @(negedge clk) begin
        if (rst) cut_q <= 1'b0;
        else     cut_q <= in_pulse && ack && !late_release;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign we_n[g] = !(in_pulse && mask[g] && !cut_q);
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_pulse |-> (&we_n));

    // R7
    masked_lane_chk: assert property (@(posedge clk) disable iff (rst)
        ((~we_n) & ~mask) == '0);

    // R3
    release_by_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (in_pulse && ack) |=> (&we_n));

endmodule

// File: rtl/sram_wpulse_gen.sv
module sram_wpulse_gen
    import sramw_pkg::*;
#(
    parameter int LANES = 8,
    parameter int BEATS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_start,
    input  logic             line_fill,
    input  logic [LANES-1:0] lane_en,
    input  logic             wtime_cfg,
    input  logic [1:0]       mem_kind,
    input  logic             xfer_ack,
    output logic [LANES-1:0] we_n,
    output logic             adsp_sel
);

    wphase_e          phase;
    logic             capture;
    wcfg_t            cfg;
    logic [LANES-1:0] mask_q;

    sramw_beat_fsm #(.BEATS(BEATS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (wr_start),
        .ack     (xfer_ack),
        .phase   (phase),
        .capture (capture)
    );

    sramw_cfg_latch #(.LANES(LANES)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .line_fill (line_fill),
        .lane_en   (lane_en),
        .wtime_cfg (wtime_cfg),
        .mem_kind  (mem_kind),
        .cfg       (cfg),
        .mask_q    (mask_q)
    );

    sramw_strobe_drv #(.LANES(LANES)) u_drv (
        .clk          (clk),
        .rst          (rst),
        .phase        (phase),
        .ack          (xfer_ack),
        .late_release (cfg.late_release),
        .mask         (mask_q),
        .we_n         (we_n)
    );

    assign adsp_sel = cfg.adsp_sel;

endmodule

// File: tb/sim_sram_wpulse_gen.sv
module sim_sram_wpulse_gen;

    localparam int LANES = 8;
    localparam int BEATS = 4;
    localparam logic [LANES-1:0] ALL1 = '1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_start = 1'b0;
    logic             line_fill = 1'b0;
    logic [LANES-1:0] lane_en = '0;
    logic             wtime_cfg = 1'b0;
    logic [1:0]       mem_kind = 2'd0;
    logic             xfer_ack = 1'b0;
    logic [LANES-1:0] we_n;
    logic             adsp_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sram_wpulse_gen #(.LANES(LANES), .BEATS(BEATS)) u0 (
        .clk(clk), .rst(rst), .wr_start(wr_start), .line_fill(line_fill),
        .lane_en(lane_en), .wtime_cfg(wtime_cfg), .mem_kind(mem_kind),
        .xfer_ack(xfer_ack), .we_n(we_n), .adsp_sel(adsp_sel)
    );

    task automatic chk(string req, logic [LANES-1:0] act, logic [LANES-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Opens a transfer; returns at posedge+1 of the first pulse cycle.
    task automatic open_xfer(logic [LANES-1:0] m, logic fill, logic tb, logic [1:0] kind);
        @(posedge clk); #1;
        wr_start = 1'b1; lane_en = m; line_fill = fill; wtime_cfg = tb; mem_kind = kind;
        @(posedge clk); #1;
        wr_start = 1'b0;
    endtask

    // One beat with wait cycles; entry and exit at posedge+1.
    task automatic one_beat(string req, int waits, logic late, logic [LANES-1:0] m,
                            logic ack_in_gap);
        for (int w = 0; w < waits; w++) begin
            #2 chk("R1", we_n, ~m);
            #5 chk("R1", we_n, ~m);
            @(posedge clk); #1;
        end
        xfer_ack = 1'b1;
        #2 chk(req, we_n, ~m);
        #5 chk(req, we_n, late ? ~m : ALL1);
        @(posedge clk); #1;
        xfer_ack = ack_in_gap;
        #2 chk("R8", we_n, ALL1);
        #5 chk("R8", we_n, ALL1);
        @(posedge clk); #1;
        xfer_ack = 1'b0;
    endtask

    task automatic burst(string req, logic [LANES-1:0] m, logic fill, logic tb,
                         logic [1:0] kind, logic late);
        open_xfer(m, fill, tb, kind);
        for (int b = 0; b < BEATS; b++) one_beat(req, 0, late, m, 1'b0);
        // R9: back in idle
        #2 chk("R9", we_n, ALL1);
    endtask

    task automatic t_reset();
        chk("R9", we_n, ALL1);
        chk("R6", {7'd0, adsp_sel}, 8'd0);
    endtask

    task automatic t_early_cfg0();  burst("R2", 8'hFF, 1'b1, 1'b0, 2'd0, 1'b0); endtask
    task automatic t_late_fill();   burst("R3", 8'hFF, 1'b1, 1'b1, 2'd0, 1'b1); endtask
    task automatic t_nofill();      burst("R4", 8'hFF, 1'b0, 1'b1, 2'd0, 1'b0); endtask
    task automatic t_sync();        burst("R5", 8'hFF, 1'b1, 1'b1, 2'd1, 1'b0); endtask
    task automatic t_rsvd();        burst("R5", 8'hFF, 1'b1, 1'b1, 2'd3, 1'b0); endtask

    task automatic t_pipe();
        @(posedge clk); #1;
        mem_kind = 2'd2; wtime_cfg = 1'b1;
        #2 chk("R6", {7'd0, adsp_sel}, 8'd1);
        wtime_cfg = 1'b0;
        #1 chk("R6", {7'd0, adsp_sel}, 8'd0);
        mem_kind = 2'd0; wtime_cfg = 1'b1;
        #1 chk("R6", {7'd0, adsp_sel}, 8'd0);
        burst("R6", 8'hFF, 1'b1, 1'b1, 2'd2, 1'b0);
    endtask

    task automatic t_mask();
        burst("R7", 8'hA5, 1'b1, 1'b1, 2'd0, 1'b1);
        burst("R7", 8'h0F, 1'b0, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_waits();
        open_xfer(8'h3C, 1'b1, 1'b1, 2'd0);
        one_beat("R1", 3, 1'b1, 8'h3C, 1'b0);
        one_beat("R1", 1, 1'b1, 8'h3C, 1'b0);
        one_beat("R1", 0, 1'b1, 8'h3C, 1'b0);
        one_beat("R1", 2, 1'b1, 8'h3C, 1'b0);
        #2 chk("R9", we_n, ALL1);
    endtask

    task automatic t_gap_ack();
        // Acks in the gap must not count: still four pulses follow.
        open_xfer(8'hFF, 1'b0, 1'b0, 2'd0);
        for (int b = 0; b < BEATS; b++) one_beat("R8", 0, 1'b0, 8'hFF, 1'b1);
        #2 chk("R9", we_n, ALL1);
    endtask

    task automatic t_idle_ack();
        @(posedge clk); #1;
        xfer_ack = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #2 chk("R9", we_n, ALL1);
            #5 chk("R9", we_n, ALL1);
            @(posedge clk); #1;
        end
        xfer_ack = 1'b0;
    endtask

    initial begin : watchdog
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2 t_reset();
        t_early_cfg0();
        t_late_fill();
        t_nofill();
        t_sync();
        t_rsvd();
        t_pipe();
        t_mask();
        t_waits();
        t_gap_ack();
        t_idle_ack();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule